// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit resolves the operand of a load instruction for an accumulator machine. It takes a mode code and a 16-bit address field. From them it works out the effective address and fetches the operand. It then writes the operand into the accumulator and pulses `done_o` for one cycle.

Eight addressing modes are supported, and they differ in how many memory reads they need:
- Immediate and register modes need no read.
- Direct, register-indirect, indexed, based and stack modes need one read.
- Indirect mode needs two dependent reads: the first read returns the effective address and the second returns the operand.

The unit holds a four-entry register file with a write port:
- Entry 1 is the index register.
- Entry 2 is the base register.
- Entry 3 is the stack pointer.

Data memory is external. It is reached through a single-outstanding read port: a request pulse, then a valid strobe carrying the data, with any latency. A request is accepted only while the unit is idle. All address sums wrap modulo 2^16.

Top module: `ea_resolver`

## Requirements
- R1: After reset, `acc_o`, `ea_o` and `operand_o` are zero, and `done_o`, `illegal_o`, `busy_o` and `mem_req_o` are low.
- R2: Immediate mode (code 0) makes the operand equal to the field, reports `ea_o` = 0 and issues no memory read. `done_o` is high in the second cycle after the cycle in which `start_i` is sampled.
- R3: Direct mode (code 1) uses the field as effective address and returns the word read there, with exactly one read.
- R4: Register mode (code 2) returns the register selected by field bits [1:0] (upper field bits ignored), reports `ea_o` = 0, issues no read, and completes with the same timing as R2.
- R5: Indirect mode (code 3) issues two reads: first at the field, then at the word returned. `ea_o` is that returned word and the operand is the second word read.
- R6: Register-indirect mode (code 4) uses the register selected by field bits [1:0] as effective address, with one read.
- R7: Indexed mode (code 5) uses field + register 1, modulo 2^16, as effective address, with one read.
- R8: Based mode (code 6) uses register 2 + field, modulo 2^16, as effective address, with one read.
- R9: Stack mode (code 7) uses register 3 as effective address, ignoring the field, with one read.
- R10: Codes 8 to 15 raise `illegal_o` together with `done_o` (same timing as R2), issue no read and leave `acc_o` unchanged.
- R11: `done_o` lasts exactly one cycle. On a legal completion `acc_o` equals `operand_o` from the `done_o` cycle on, and holds until the next completion.
- R12: `start_i` is ignored while `busy_o` is high. The running resolution finishes unchanged, and no extra completion follows.
- R13: A register write in the same cycle as `start_i` is seen by that resolution.
- R14: `mem_req_o` is a one-cycle pulse, and no new request is issued while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_we_i | input | 1 | Register file write enable |
| rf_waddr_i | input | 2 | Register file write index |
| rf_wdata_i | input | 16 | Register file write data |
| start_i | input | 1 | Begin a resolution (accepted when idle) |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | 16 | Instruction address field |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | 16 | Memory read address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 16 | Memory read data |
| ea_o | output | 16 | Effective address of the last resolution |
| operand_o | output | 16 | Operand of the last resolution |
| acc_o | output | 16 | Accumulator |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Illegal mode, valid with `done_o` |
| busy_o | output | 1 | Resolution in progress |

## Verification
Two functions can fall in the same cycle.

- **Register write and `start_i`.** A register write can coincide with the `start_i` that begins an indexed resolution. The bench drives both on one edge, so the new index value must appear in the effective address; the stale value would give a different sum.
- **`start_i` while busy.** A fresh `start_i` can land while a direct read is still waiting on a slow memory. The bench pulses start mid-resolution. It then checks two things: the operand and address still belong to the first request, and `done_o` stays low for the following cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_DIR  = 3'd1,
    AM_REG  = 3'd2,
    AM_IND  = 3'd3,
    AM_RIND = 3'd4,
    AM_IDX  = 3'd5,
    AM_BASE = 3'd6,
    AM_STK  = 3'd7
  } am_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DEC  = 3'd1,
    S_REQ  = 3'd2,
    S_WAIT = 3'd3,
    S_DONE = 3'd4
  } seq_e;

  localparam int unsigned NUM_MODES = 8;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned REG_N    = 4,
  parameter int unsigned IDX_REG  = 1,
  parameter int unsigned BASE_REG = 2,
  parameter int unsigned SP_REG   = 3,
  localparam int unsigned SEL_W   = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  rsel_i,
  output logic [DATA_W-1:0] rsel_o,
  output logic [DATA_W-1:0] idx_o,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] sp_o
);
  logic [DATA_W-1:0] regs [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= '0;
      else if (we_i && waddr_i == SEL_W'(g))     q <= wdata_i;
    end
    assign regs[g] = q;
  end

  assign rsel_o = regs[rsel_i];
  assign idx_o  = regs[IDX_REG];
  assign base_o = regs[BASE_REG];
  assign sp_o   = regs[SP_REG];

  // R13
  wr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc import ea_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MODE_W = 4
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] field_i,
  input  logic [DATA_W-1:0] rsel_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] sp_i,
  output logic              legal_o,
  output logic              need_mem_o,
  output logic              two_reads_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] direct_val_o
);
  am_e am;

  always_comb begin
    legal_o      = (32'(mode_i) < NUM_MODES);
    am           = am_e'(mode_i[2:0]);
    need_mem_o   = 1'b1;
    two_reads_o  = 1'b0;
    addr_o       = field_i;
    direct_val_o = '0;
    case (am)
      AM_IMM:  begin need_mem_o = 1'b0; direct_val_o = field_i; end
      AM_REG:  begin need_mem_o = 1'b0; direct_val_o = rsel_i;  end
      AM_DIR:  addr_o = field_i;
      AM_IND:  begin addr_o = field_i; two_reads_o = 1'b1; end
      AM_RIND: addr_o = rsel_i;
      AM_IDX:  addr_o = field_i + idx_i;   // wraps at DATA_W
      AM_BASE: addr_o = base_i + field_i;  // displacement from base
      AM_STK:  addr_o = sp_i;
      default: addr_o = field_i;
    endcase
  end
endmodule

// File: rtl/ea_seq.sv
module ea_seq import ea_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] field_i,
  output logic [MODE_W-1:0] mode_q_o,
  output logic [DATA_W-1:0] field_q_o,
  input  logic              legal_i,
  input  logic              need_mem_i,
  input  logic              two_reads_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] direct_val_i,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] operand_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              busy_o
);
  seq_e              state_q;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] field_q, addr_q, ea_q, op_q, acc_q;
  logic              hop_q, ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      field_q <= '0;
      addr_q  <= '0;
      ea_q    <= '0;
      op_q    <= '0;
      acc_q   <= '0;
      hop_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          field_q <= field_i;
          ill_q   <= 1'b0;
          state_q <= S_DEC;
        end
        S_DEC: begin
          if (!legal_i) begin
            ill_q   <= 1'b1;
            state_q <= S_DONE;
          end else if (!need_mem_i) begin
            ea_q    <= '0;
            op_q    <= direct_val_i;
            acc_q   <= direct_val_i;
            state_q <= S_DONE;
          end else begin
            addr_q  <= addr_i;
            hop_q   <= two_reads_i;
            ea_q    <= two_reads_i ? '0 : addr_i;
            state_q <= S_REQ;
          end
        end
        S_REQ: state_q <= S_WAIT;
        S_WAIT: if (mem_rvalid_i) begin
          if (hop_q) begin
            // pointer word arrives: it is the effective address
            hop_q   <= 1'b0;
            addr_q  <= mem_rdata_i;
            ea_q    <= mem_rdata_i;
            state_q <= S_REQ;
          end else begin
            op_q    <= mem_rdata_i;
            acc_q   <= mem_rdata_i;
            state_q <= S_DONE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mode_q_o   = mode_q;
  assign field_q_o  = field_q;
  assign mem_req_o  = (state_q == S_REQ);
  assign mem_addr_o = addr_q;
  assign ea_o       = ea_q;
  assign operand_o  = op_q;
  assign acc_o      = acc_q;
  assign done_o     = (state_q == S_DONE);
  assign illegal_o  = done_o && ill_q;
  assign busy_o     = (state_q != S_IDLE);

  // R14
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  acc_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o) |-> acc_o == operand_o);
  // R10
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(acc_o));
  // R12
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(field_q));
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver import ea_pkg::*; #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MODE_W   = 4,
  parameter int unsigned REG_N    = 4,
  parameter int unsigned IDX_REG  = 1,
  parameter int unsigned BASE_REG = 2,
  parameter int unsigned SP_REG   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rf_we_i,
  input  logic [$clog2(REG_N)-1:0] rf_waddr_i,
  input  logic [DATA_W-1:0]        rf_wdata_i,
  input  logic                     start_i,
  input  logic [MODE_W-1:0]        mode_i,
  input  logic [DATA_W-1:0]        field_i,
  output logic                     mem_req_o,
  output logic [DATA_W-1:0]        mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [DATA_W-1:0]        ea_o,
  output logic [DATA_W-1:0]        operand_o,
  output logic [DATA_W-1:0]        acc_o,
  output logic                     done_o,
  output logic                     illegal_o,
  output logic                     busy_o
);
  localparam int unsigned SEL_W = $clog2(REG_N);

  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] field_q, rsel_val, idx_val, base_val, sp_val;
  logic [DATA_W-1:0] calc_addr, calc_val;
  logic              calc_legal, calc_mem, calc_two;

  ea_regfile #(
    .DATA_W(DATA_W), .REG_N(REG_N),
    .IDX_REG(IDX_REG), .BASE_REG(BASE_REG), .SP_REG(SP_REG)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we_i),
    .waddr_i (rf_waddr_i),
    .wdata_i (rf_wdata_i),
    .rsel_i  (field_q[SEL_W-1:0]),
    .rsel_o  (rsel_val),
    .idx_o   (idx_val),
    .base_o  (base_val),
    .sp_o    (sp_val)
  );

  ea_addr_calc #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_calc (
    .mode_i       (mode_q),
    .field_i      (field_q),
    .rsel_i       (rsel_val),
    .idx_i        (idx_val),
    .base_i       (base_val),
    .sp_i         (sp_val),
    .legal_o      (calc_legal),
    .need_mem_o   (calc_mem),
    .two_reads_o  (calc_two),
    .addr_o       (calc_addr),
    .direct_val_o (calc_val)
  );

  ea_seq #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .field_i      (field_i),
    .mode_q_o     (mode_q),
    .field_q_o    (field_q),
    .legal_i      (calc_legal),
    .need_mem_i   (calc_mem),
    .two_reads_i  (calc_two),
    .addr_i       (calc_addr),
    .direct_val_i (calc_val),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .ea_o         (ea_o),
    .operand_o    (operand_o),
    .acc_o        (acc_o),
    .done_o       (done_o),
    .illegal_o    (illegal_o),
    .busy_o       (busy_o)
  );

  // R10
  illegal_nomem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_o && !$past(mem_req_o));
endmodule

// File: tb/ea_resolver_tb.sv
module ea_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_we = 1'b0;
  logic [1:0]  rf_waddr = '0;
  logic [15:0] rf_wdata = '0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] field = '0;
  logic        mem_req, mem_rvalid, done, illegal, busy;
  logic [15:0] mem_addr, mem_rdata, ea, operand, acc;

  always #2 clk = ~clk;  // 250 MHz

  ea_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rf_we_i(rf_we), .rf_waddr_i(rf_waddr), .rf_wdata_i(rf_wdata),
    .start_i(start), .mode_i(mode), .field_i(field),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .ea_o(ea), .operand_o(operand), .acc_o(acc),
    .done_o(done), .illegal_o(illegal), .busy_o(busy)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C3C;
  endfunction

  // memory model with programmable latency
  int          mem_lat = 1;
  logic        clr_log = 1'b0;
  logic        pend;
  int          cnt;
  logic [15:0] paddr;
  int          nreq;
  logic        overlap;
  logic [15:0] a0, a1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0; cnt <= 0; paddr <= '0;
      nreq <= 0; overlap <= 1'b0; a0 <= '0; a1 <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (clr_log) begin nreq <= 0; overlap <= 1'b0; end
      if (mem_req) begin
        if (pend) overlap <= 1'b1;
        pend <= 1'b1; cnt <= mem_lat; paddr <= mem_addr;
        if (nreq == 0) a0 <= mem_addr;
        if (nreq == 1) a1 <= mem_addr;
        nreq <= nreq + 1;
      end else if (pend) begin
        if (cnt <= 1) begin
          mem_rvalid <= 1'b1; mem_rdata <= mem_f(paddr); pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [15:0] rmod [4];
  logic [15:0] acc_mod = '0;

  task automatic wr_reg(input logic [1:0] i, input logic [15:0] v);
    @(negedge clk); rf_we = 1'b1; rf_waddr = i; rf_wdata = v;
    @(negedge clk); rf_we = 1'b0;
    rmod[i] = v;
  endtask

  task automatic run_op(input logic [3:0] m, input logic [15:0] f, input int lat, output int cyc);
    @(negedge clk); mem_lat = lat; clr_log = 1'b1; start = 1'b1; mode = m; field = f;
    @(negedge clk); clr_log = 1'b0; start = 1'b0; cyc = 1;
    while (!done && cyc < 60) begin @(negedge clk); cyc++; end
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R8";
      4'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  // {mode, field, latency}
  localparam logic [21:0] VEC [15] = '{
    {4'd0, 16'h1234, 2'd1},
    {4'd1, 16'h00A5, 2'd1},
    {4'd2, 16'h0002, 2'd1},
    {4'd2, 16'hFFF1, 2'd1},
    {4'd3, 16'h0040, 2'd1},
    {4'd3, 16'h1357, 2'd3},
    {4'd4, 16'h0003, 2'd2},
    {4'd5, 16'h0800, 2'd1},
    {4'd5, 16'hF900, 2'd2},
    {4'd6, 16'h0010, 2'd1},
    {4'd6, 16'hFFFF, 2'd3},
    {4'd7, 16'hBEEF, 2'd1},
    {4'd9, 16'h0000, 2'd1},
    {4'd15, 16'h7777, 2'd2},
    {4'd1, 16'h0000, 2'd2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < 4; i++) rmod[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 acc", acc, 0);
    check("R1 ea", ea, 0);
    check("R1 operand", operand, 0);
    check("R1 flags", {28'd0, done, illegal, busy, mem_req}, 0);
    rst_n = 1'b1;

    wr_reg(2'd0, 16'h1111);
    wr_reg(2'd1, 16'h0800);
    wr_reg(2'd2, 16'h4000);
    wr_reg(2'd3, 16'hFFF0);

    for (int v = 0; v < 15; v++) begin
      logic [3:0]  m;
      logic [15:0] f, e_ea, e_op, e_a0, e_a1;
      int          e_n;
      logic        e_ill;
      m = VEC[v][21:18]; f = VEC[v][17:2];
      e_ill = 1'b0; e_n = 1; e_ea = '0; e_op = '0; e_a0 = '0; e_a1 = '0;
      case (m)
        4'd0: begin e_n = 0; e_op = f; end
        4'd1: begin e_ea = f; end
        4'd2: begin e_n = 0; e_op = rmod[f[1:0]]; end
        4'd3: begin e_n = 2; e_ea = mem_f(f); e_a1 = e_ea; e_a0 = f; end
        4'd4: begin e_ea = rmod[f[1:0]]; end
        4'd5: begin e_ea = f + rmod[1]; end
        4'd6: begin e_ea = rmod[2] + f; end
        4'd7: begin e_ea = rmod[3]; end
        default: begin e_n = 0; e_ill = 1'b1; end
      endcase
      if (m != 4'd3 && e_n == 1) e_a0 = e_ea;
      if (e_n > 0) e_op = mem_f(e_ea);
      run_op(m, f, int'(VEC[v][1:0]), cyc);
      check({tag_of(m), " done"}, done, 1);
      check({tag_of(m), " illegal"}, illegal, e_ill);
      check({tag_of(m), " reads"}, nreq, e_n);
      check("R14 overlap", overlap, 0);
      if (e_n == 0) check({tag_of(m), " latency"}, cyc, 2);
      if (e_n > 0) check({tag_of(m), " first addr"}, a0, e_a0);
      if (e_n == 2) check("R5 second addr", a1, e_a1);
      if (e_ill) begin
        check("R10 acc unchanged", acc, acc_mod);
      end else begin
        check({tag_of(m), " ea"}, ea, e_ea);
        check({tag_of(m), " operand"}, operand, e_op);
        check("R11 acc", acc, e_op);
        acc_mod = e_op;
      end
      @(negedge clk);
      check("R11 done pulse", done, 0);
      check("R11 acc hold", acc, acc_mod);
    end

    // R13: register write together with start
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 2'd1; rf_wdata = 16'h2000;
    mem_lat = 1; clr_log = 1'b1; start = 1'b1; mode = 4'd5; field = 16'h0005;
    @(negedge clk); rf_we = 1'b0; clr_log = 1'b0; start = 1'b0; rmod[1] = 16'h2000;
    cyc = 1;
    while (!done && cyc < 60) begin @(negedge clk); cyc++; end
    check("R13 ea", ea, 16'h2005);
    check("R13 operand", operand, mem_f(16'h2005));
    acc_mod = mem_f(16'h2005);

    // R12: start while busy is ignored
    @(negedge clk); mem_lat = 3; clr_log = 1'b1; start = 1'b1; mode = 4'd1; field = 16'h0321;
    @(negedge clk); clr_log = 1'b0; start = 1'b0;
    @(negedge clk); start = 1'b1; mode = 4'd0; field = 16'hAAAA;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 60) begin @(negedge clk); cyc++; end
    check("R12 operand", operand, mem_f(16'h0321));
    check("R12 ea", ea, 16'h0321);
    check("R12 reads", nreq, 1);
    begin
      int extra = 0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (done) extra++; end
      check("R12 no extra done", extra, 0);
      check("R12 idle", busy, 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule